// File: doc/BRIEF.md
# TCP Splice Sequence Rewriter

This block is one stage of the per-packet datapath in a content switch. The switch terminates a client's TCP connection, picks a back-end server, opens a second connection to that server and then joins the two into a single splice. Each packet handed to the stage carries its already parsed direction, sequence number, acknowledgement number and TCP checksum. It also carries the splice context: the initial sequence number the switch sent to the client, and the initial sequence number the server returned.

The client's own sequence space is reused unchanged on the server leg, so only the two server-side spaces need translating. The stage keeps the difference between the switch's and the server's initial numbers. It adds that difference to the sequence field of server-to-client packets and subtracts it from the acknowledgement field of client-to-server packets. The checksum is patched incrementally, so the payload never has to be summed again. Packets that are not spliced leave exactly as they came in.

The stage is a single register slice with a valid/ready handshake on both sides. It accepts one packet per cycle, and each result appears one cycle after it is accepted.

Top module: `tcp_splice_rewriter`

## Requirements
- R1: With splice set and direction 1 (server to client), the output sequence equals input sequence + (switch initial number − server initial number) and the acknowledgement is unchanged.
- R2: With splice set and direction 0 (client to server), the output acknowledgement equals input acknowledgement − (switch initial number − server initial number) and the sequence is unchanged.
- R3: When a field is rewritten, the output checksum equals the one's-complement update of the input checksum for the old and new 32-bit values, each taken as two 16-bit words. 0x0000 and 0xFFFF count as the same value.
- R4: With splice clear, sequence, acknowledgement and checksum leave bit-identical to the input in either direction.
- R5: All sequence and acknowledgement arithmetic wraps modulo 2^32.
- R6: A packet accepted on a clock edge (in_valid_i and in_ready_o both high) is presented with out_valid_o high from that edge on.
- R7: While out_valid_o is high and out_ready_i is low, the output fields and out_valid_o hold steady.
- R8: During and directly after reset out_valid_o is low.
- R9: in_ready_o is high whenever the output slot is empty or being consumed in the same cycle, so back-to-back packets pass at one per cycle. It is low while a held result is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input packet fields valid |
| in_ready_o | output | 1 | Stage can take a packet |
| in_dir_i | input | 1 | 0 client to server, 1 server to client |
| in_splice_i | input | 1 | Packet belongs to an established splice |
| in_seq_i | input | 32 | TCP sequence number |
| in_ack_i | input | 32 | TCP acknowledgement number |
| in_csum_i | input | 16 | TCP checksum |
| ctx_dseq_i | input | 32 | Switch initial sequence toward the client |
| ctx_sseq_i | input | 32 | Server initial sequence |
| out_valid_o | output | 1 | Output packet fields valid |
| out_ready_i | input | 1 | Downstream takes the output |
| out_dir_o | output | 1 | Direction, passed through |
| out_seq_o | output | 32 | Rewritten sequence number |
| out_ack_o | output | 32 | Rewritten acknowledgement number |
| out_csum_o | output | 16 | Patched checksum |

## Verification
The cycle that needs care is the one in which a held result is consumed downstream while a new packet is accepted into the same slot. If this goes wrong, a result is lost or duplicated even though the arithmetic is right. The bench sets this up with a pseudo-random downstream ready pattern over a back-to-back stream, and with a deliberate stall that is released while a second packet is waiting. A scoreboard checks that every packet comes out in order, exactly once, with its translated fields and a checksum that matches a full recomputation over the packet's words.

// File: rtl/splice_pkg.sv
package splice_pkg;
  localparam int SEQ_W  = 32;
  localparam int CSUM_W = 16;

  typedef enum logic {
    DIR_C2S = 1'b0,
    DIR_S2C = 1'b1
  } dir_e;

  typedef struct packed {
    dir_e              dir;
    logic [SEQ_W-1:0]  seq;
    logic [SEQ_W-1:0]  ack;
    logic [CSUM_W-1:0] csum;
  } hdr_t;
endpackage

// File: rtl/splice_seq_xlate.sv
module splice_seq_xlate
  import splice_pkg::*;
#(
  parameter int W = SEQ_W
) (
  input  dir_e         dir_i,
  input  logic         splice_i,
  input  logic [W-1:0] seq_i,
  input  logic [W-1:0] ack_i,
  input  logic [W-1:0] dseq_i,
  input  logic [W-1:0] sseq_i,
  output logic [W-1:0] seq_o,
  output logic [W-1:0] ack_o,
  output logic [W-1:0] old_fld_o,
  output logic [W-1:0] new_fld_o
);
  logic [W-1:0] delta;
  assign delta = dseq_i - sseq_i;  // modulo 2^W

  always_comb begin
    seq_o     = seq_i;
    ack_o     = ack_i;
    old_fld_o = ack_i;
    new_fld_o = ack_i;
    if (splice_i) begin
      if (dir_i == DIR_S2C) begin
        seq_o     = seq_i + delta;
        old_fld_o = seq_i;
        new_fld_o = seq_i + delta;
      end else begin
        ack_o     = ack_i - delta;
        new_fld_o = ack_i - delta;
      end
    end
  end
endmodule

// File: rtl/splice_csum_fix.sv
module splice_csum_fix
  import splice_pkg::*;
#(
  parameter int FLD_W = SEQ_W,
  parameter int CS_W  = CSUM_W
) (
  input  logic            en_i,
  input  logic [CS_W-1:0] csum_i,
  input  logic [FLD_W-1:0] old_i,
  input  logic [FLD_W-1:0] new_i,
  output logic [CS_W-1:0] csum_o
);
  localparam int NW    = FLD_W / CS_W;
  localparam int ACC_W = 2 * CS_W;

  logic [ACC_W-1:0] part [NW+1];
  logic [CS_W-1:0]  inv_csum;

  assign inv_csum = ~csum_i;
  assign part[0]  = {{(ACC_W-CS_W){1'b0}}, inv_csum};

  for (genvar i = 0; i < NW; i++) begin : g_word
    logic [CS_W-1:0] inv_old;
    logic [CS_W-1:0] nw;
    assign inv_old   = ~old_i[i*CS_W +: CS_W];
    assign nw        = new_i[i*CS_W +: CS_W];
    assign part[i+1] = part[i]
                     + {{(ACC_W-CS_W){1'b0}}, inv_old}
                     + {{(ACC_W-CS_W){1'b0}}, nw};
  end

  logic [CS_W:0] fold1;
  logic [CS_W:0] fold2;
  assign fold1 = {1'b0, part[NW][CS_W-1:0]} + {1'b0, part[NW][ACC_W-1:CS_W]};
  assign fold2 = {1'b0, fold1[CS_W-1:0]} + {{CS_W{1'b0}}, fold1[CS_W]};

  assign csum_o = en_i ? ~fold2[CS_W-1:0] : csum_i;
endmodule

// File: rtl/splice_pipe_stage.sv
module splice_pipe_stage
  import splice_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic in_ready_o,
  input  hdr_t in_data_i,
  output logic out_valid_o,
  input  logic out_ready_i,
  output hdr_t out_data_o
);
  logic valid_q;
  hdr_t data_q;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i;
    end
  end
endmodule

// File: rtl/tcp_splice_rewriter.sv
module tcp_splice_rewriter
  import splice_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_dir_i,
  input  logic              in_splice_i,
  input  logic [SEQ_W-1:0]  in_seq_i,
  input  logic [SEQ_W-1:0]  in_ack_i,
  input  logic [CSUM_W-1:0] in_csum_i,
  input  logic [SEQ_W-1:0]  ctx_dseq_i,
  input  logic [SEQ_W-1:0]  ctx_sseq_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_dir_o,
  output logic [SEQ_W-1:0]  out_seq_o,
  output logic [SEQ_W-1:0]  out_ack_o,
  output logic [CSUM_W-1:0] out_csum_o
);
  dir_e             dir;
  logic [SEQ_W-1:0] nseq, nack, fld_old, fld_new;
  logic [CSUM_W-1:0] ncsum;
  hdr_t             nxt, cur;

  assign dir = dir_e'(in_dir_i);

  splice_seq_xlate #(.W(SEQ_W)) u_xlate (
    .dir_i     (dir),
    .splice_i  (in_splice_i),
    .seq_i     (in_seq_i),
    .ack_i     (in_ack_i),
    .dseq_i    (ctx_dseq_i),
    .sseq_i    (ctx_sseq_i),
    .seq_o     (nseq),
    .ack_o     (nack),
    .old_fld_o (fld_old),
    .new_fld_o (fld_new)
  );

  splice_csum_fix #(.FLD_W(SEQ_W), .CS_W(CSUM_W)) u_csum (
    .en_i   (in_splice_i),
    .csum_i (in_csum_i),
    .old_i  (fld_old),
    .new_i  (fld_new),
    .csum_o (ncsum)
  );

  always_comb begin
    nxt.dir  = dir;
    nxt.seq  = nseq;
    nxt.ack  = nack;
    nxt.csum = ncsum;
  end

  splice_pipe_stage u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (nxt),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (cur)
  );

  assign out_dir_o  = cur.dir;
  assign out_seq_o  = cur.seq;
  assign out_ack_o  = cur.ack;
  assign out_csum_o = cur.csum;
endmodule

// File: rtl/splice_rewriter_chk.sv
module splice_rewriter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        in_dir_i,
  input logic        in_splice_i,
  input logic [31:0] in_seq_i,
  input logic [31:0] in_ack_i,
  input logic [15:0] in_csum_i,
  input logic [31:0] ctx_dseq_i,
  input logic [31:0] ctx_sseq_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic        out_dir_o,
  input logic [31:0] out_seq_o,
  input logic [31:0] out_ack_o,
  input logic [15:0] out_csum_o
);
  logic acc;
  assign acc = in_valid_i && in_ready_o;

  p_accept_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_seq_o) && $stable(out_ack_o) && $stable(out_csum_o)));

  p_bypass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !in_splice_i) |=>
      (out_seq_o == $past(in_seq_i) && out_ack_o == $past(in_ack_i)
       && out_csum_o == $past(in_csum_i)));

  p_c2s_seq_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !in_dir_i) |=> out_seq_o == $past(in_seq_i));

  p_s2c_ack_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_dir_i) |=> out_ack_o == $past(in_ack_i));

  p_s2c_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_splice_i && in_dir_i) |=>
      out_seq_o == $past(in_seq_i) + ($past(ctx_dseq_i) - $past(ctx_sseq_i)));
endmodule

bind tcp_splice_rewriter splice_rewriter_chk u_chk (.*);

// File: tb/sim_tcp_splice_rewriter.sv
module sim_tcp_splice_rewriter;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        rst_n;
  logic        in_valid, in_ready, in_dir, in_splice;
  logic [31:0] in_seq, in_ack, dseq, sseq;
  logic [15:0] in_csum;
  logic        out_valid, out_ready, out_dir;
  logic [31:0] out_seq, out_ack;
  logic [15:0] out_csum;

  tcp_splice_rewriter u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_dir_i(in_dir), .in_splice_i(in_splice),
    .in_seq_i(in_seq), .in_ack_i(in_ack), .in_csum_i(in_csum),
    .ctx_dseq_i(dseq), .ctx_sseq_i(sseq),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_dir_o(out_dir), .out_seq_o(out_seq), .out_ack_o(out_ack),
    .out_csum_o(out_csum)
  );

  typedef struct {
    logic        dir;
    logic [31:0] seq;
    logic [31:0] ack;
    logic [15:0] csum;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  int rmode = 0;
  logic hold_low = 1'b0;

  function automatic logic [15:0] full_csum(logic [15:0] rest, logic [31:0] s, logic [31:0] a);
    logic [31:0] t;
    t = {16'h0, rest} + {16'h0, s[31:16]} + {16'h0, s[15:0]}
      + {16'h0, a[31:16]} + {16'h0, a[15:0]};
    t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    return ~t[15:0];
  endfunction

  function automatic logic [15:0] norm(logic [15:0] c);
    return (c == 16'hFFFF) ? 16'h0000 : c;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic dir, logic spl, logic [31:0] s, logic [31:0] a,
                      logic [15:0] rest, logic [31:0] d, logic [31:0] v, string tag);
    exp_t e;
    logic [31:0] off;
    logic [15:0] cin;
    cin   = full_csum(rest, s, a);
    off   = d - v;
    e.dir = dir; e.seq = s; e.ack = a; e.tag = tag;
    if (spl) begin
      if (dir) e.seq = s + off;
      else     e.ack = a - off;
      e.csum = full_csum(rest, e.seq, e.ack);
    end else begin
      e.csum = cin;
    end
    sb.push_back(e);
    in_valid = 1'b1; in_dir = dir; in_splice = spl;
    in_seq = s; in_ack = a; in_csum = cin; dseq = d; sseq = v;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
    @(posedge clk); #1;
  endtask

  // downstream ready
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (hold_low) out_ready <= 1'b0;
    else if (rmode == 0) out_ready <= 1'b1;
    else out_ready <= lfsr[0];
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6 unexpected output act=%h exp=none", out_seq);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "seq", out_seq, e.seq);
        check(e.tag, "ack", out_ack, e.ack);
        check({e.tag, " R3"}, "csum", {16'h0, norm(out_csum)}, {16'h0, norm(e.csum)});
        check(e.tag, "dir", {31'h0, out_dir}, {31'h0, e.dir});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; in_valid = 1'b0; in_dir = 1'b0; in_splice = 1'b0;
    in_seq = '0; in_ack = '0; in_csum = '0; dseq = '0; sseq = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "out_valid in reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "out_valid after reset", {31'h0, out_valid}, 32'h0);
    check("R9", "in_ready when empty", {31'h0, in_ready}, 32'h1);
    @(posedge clk); #1;

    // R1: server to client
    send(1'b1, 1'b1, 32'h2000_0001, 32'h0000_5001, 16'h1234, 32'h1000_0000, 32'h2000_0000, "R1");
    send(1'b1, 1'b1, 32'h2000_0400, 32'h0000_5100, 16'hBEEF, 32'h1000_0000, 32'h2000_0000, "R1");
    send(1'b1, 1'b1, 32'h7777_0000, 32'hABCD_EF01, 16'h0000, 32'h9000_1111, 32'h7776_FFFF, "R1");
    // R2: client to server
    send(1'b0, 1'b1, 32'h0000_5001, 32'h1000_0001, 16'h4321, 32'h1000_0000, 32'h2000_0000, "R2");
    send(1'b0, 1'b1, 32'h0000_5200, 32'h1000_8001, 16'hFFFF, 32'h1000_0000, 32'h2000_0000, "R2");
    // R5: wrap in both directions
    send(1'b1, 1'b1, 32'hFFFF_FFF0, 32'h0, 16'h0F0F, 32'h0000_0100, 32'h0000_0010, "R5");
    send(1'b0, 1'b1, 32'h1, 32'h0000_0005, 16'h0F0F, 32'h0000_0100, 32'h0000_0010, "R5");
    send(1'b0, 1'b1, 32'h1, 32'hFFFF_FFFE, 16'h0A0A, 32'h0000_0010, 32'h0000_0100, "R5");
    // R4: splice clear
    send(1'b1, 1'b0, 32'hDEAD_BEEF, 32'h0BAD_F00D, 16'h5555, 32'h1000_0000, 32'h2000_0000, "R4");
    send(1'b0, 1'b0, 32'hCAFE_0000, 32'h0000_CAFE, 16'hAAAA, 32'h1000_0000, 32'h2000_0000, "R4");
    drain();

    // R6: latency
    send(1'b1, 1'b1, 32'h0000_1000, 32'h0, 16'h0001, 32'h5, 32'h3, "R6");
    @(negedge clk);
    check("R6", "out_valid after accept", {31'h0, out_valid}, 32'h1);
    drain();

    // R7 / R9: stall while a second packet waits, then release
    hold_low = 1'b1;
    @(posedge clk); #1;
    send(1'b1, 1'b1, 32'h0001_0000, 32'h22, 16'h0102, 32'h40, 32'h20, "R7");
    fork
      send(1'b0, 1'b1, 32'h33, 32'h0000_0050, 16'h0304, 32'h40, 32'h20, "R9");
      begin
        @(negedge clk);
        held = out_seq;
        for (int k = 0; k < 3; k++) begin
          check("R7", "out_valid held", {31'h0, out_valid}, 32'h1);
          check("R7", "out_seq held", out_seq, held);
          check("R9", "in_ready while stalled", {31'h0, in_ready}, 32'h0);
          @(negedge clk);
        end
        hold_low = 1'b0;
      end
    join
    drain();

    // R9: random backpressure, back-to-back stream
    rmode = 1;
    for (int j = 0; j < 60; j++) begin
      send(j[0], (j % 5) != 4, $urandom, $urandom, 16'($urandom), $urandom, $urandom, "R9");
    end
    drain();
    rmode = 0;
    drain();
    check("R9", "scoreboard empty", sb.size(), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule